// File: doc/BRIEF.md
# Acquisition Peak and Power Tracker

This block sits after the magnitude stage of a code-phase acquisition engine. It watches a stream of unsigned correlation magnitudes arriving as a series of Doppler sweeps. Within each sweep it keeps a running power total and the sweep's largest sample. When a sweep closes, that sweep's best sample is compared against the best seen so far in the run. The run-level peak magnitude, its sample position, the index of the sweep that held it, and that sweep's power total are kept as results.

Software or a sequencer pulses a run start with the number of sweeps to search. That clears the results. It also captures a free-running 64-bit sample counter, so the code phase of the winning peak can later be tied to absolute sample time. The captured value is presented as a low and a high 32-bit word. A one-cycle done pulse marks the end of the run.

Top module: `acq_peak_tracker`

## Requirements
- R1: After reset every result output (peak magnitude, peak index, peak sweep, power sum, both timestamp words) is zero, and busy and done are low.
- R2: A run start clears peak magnitude, peak index, peak sweep and power sum to zero on the next cycle and raises busy. It also captures the free-running sample counter value present in that cycle. The counter counts clock cycles in which sample_tick is high, starting from zero at reset.
- R3: The captured 64-bit count is split so that start_lo holds bits 31:0 and start_hi holds bits 63:32. Both words hold their value until the next run start.
- R4: A sweep's best sample replaces the stored run peak only when it is strictly greater. Within a sweep, a later sample replaces the sweep's best only when strictly greater. Equal magnitudes therefore keep the earliest sweep and the earliest position.
- R5: The peak index is the position of the sample within its sweep. The sample flagged with sweep_first is position 0, and each later accepted sample of that sweep is one higher.
- R6: The peak sweep is the ordinal of the sweep within the run. The first sweep after a run start is 0, and each later sweep_first adds one.
- R7: The power sum is the total of all accepted magnitudes of the sweep that holds the winning peak. It saturates at 0xFFFFFFFF rather than wrapping.
- R8: A sample is accepted only when mag_valid is high, busy is high, and either sweep_first is set or a sweep has already begun in the run. Samples outside these conditions change no result, and neither do the markers on cycles without mag_valid.
- R9: The run ends with the last sample of sweep number sweep_cfg-1, where a sweep_cfg of 0 counts as 1. All results are visible the cycle after that sample. busy is low from that cycle on, and done is high for exactly one cycle, one cycle later.
- R10: A run start while busy abandons the current run, clears the results as in R2, and starts a fresh run with the new sweep count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start | input | 1 | One-cycle pulse that begins a run |
| sweep_cfg | input | SWP_W (8) | Number of sweeps in the run, sampled with run_start |
| sample_tick | input | 1 | Advances the free-running sample counter |
| mag_valid | input | 1 | Magnitude sample present |
| mag_data | input | MAG_W (32) | Unsigned correlation magnitude |
| sweep_first | input | 1 | Marks the first sample of a sweep |
| sweep_last | input | 1 | Marks the last sample of a sweep |
| peak_mag | output | MAG_W (32) | Largest magnitude of the run |
| peak_idx | output | IDX_W (16) | Position of the peak within its sweep |
| peak_sweep | output | SWP_W (8) | Sweep ordinal holding the peak |
| power_sum | output | MAG_W (32) | Saturated power total of the winning sweep |
| start_lo | output | 32 | Captured sample count, low word |
| start_hi | output | 32 | Captured sample count, high word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench feeds runs whose peaks tie across positions and across sweeps. A design comparing with greater-or-equal would report the later position or sweep. It drives full-scale samples so the power total must stop at all ones; a wrapping adder would report a small value. Idle gaps carry large magnitudes and stray markers, and a large sample arrives before the first sweep marker and another after the run ends, so a design that ignores mag_valid, busy or the started condition would take a false peak. The bench also checks a one-sample sweep, a zero sweep count, a restart in the middle of a run, the exact cycle of done, and the captured counter against its own count of ticks.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic {
    RUN_IDLE   = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;

endpackage

// File: rtl/acq_stamp.sv
module acq_stamp #(
  parameter int CNT_W  = 64,
  parameter int HALF_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    capture,
  output logic [HALF_W-1:0]       stamp_lo,
  output logic [CNT_W-HALF_W-1:0] stamp_hi
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] stamp_q, stamp_d;

  always_comb begin
    cnt_d   = cnt_q;
    stamp_d = stamp_q;
    if (tick)    cnt_d   = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    if (capture) stamp_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stamp_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      stamp_q <= stamp_d;
    end
  end

  assign stamp_lo = stamp_q[HALF_W-1:0];
  assign stamp_hi = stamp_q[CNT_W-1:HALF_W];

  // R3: captured words hold between run starts
  assert_stamp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(stamp_q));

  // R2: the free-running counter never moves backwards without a tick
  assert_count_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/acq_sweep_accum.sv
module acq_sweep_accum #(
  parameter int MAG_W = 32,
  parameter int IDX_W = 16,
  parameter int SWP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             first,
  input  logic [MAG_W-1:0] mag,
  output logic             take,
  output logic [MAG_W-1:0] cand_mag,
  output logic [IDX_W-1:0] cand_idx,
  output logic [MAG_W-1:0] cand_pow,
  output logic [SWP_W-1:0] cand_sweep
);

  localparam logic [MAG_W-1:0] MAG_FULL = {MAG_W{1'b1}};

  logic             started_q, started_d;
  logic [MAG_W-1:0] pow_q, pow_d;
  logic [MAG_W-1:0] max_q, max_d;
  logic [IDX_W-1:0] maxidx_q, maxidx_d;
  logic [IDX_W-1:0] pos_q, pos_d;
  logic [SWP_W-1:0] swp_q, swp_d;

  logic [IDX_W-1:0] samp_pos;
  logic [MAG_W-1:0] pow_base;
  logic [MAG_W:0]   pow_wide;

  assign take = en & (first | started_q);

  // candidate values include the sample presented in this cycle
  always_comb begin
    samp_pos   = first ? '0 : pos_q;
    pow_base   = first ? '0 : pow_q;
    pow_wide   = {1'b0, pow_base} + {1'b0, mag};
    cand_pow   = pow_wide[MAG_W] ? MAG_FULL : pow_wide[MAG_W-1:0];
    if (first) begin
      cand_mag = mag;
      cand_idx = '0;
    end else if (mag > max_q) begin
      cand_mag = mag;
      cand_idx = pos_q;
    end else begin
      cand_mag = max_q;
      cand_idx = maxidx_q;
    end
    if (first) cand_sweep = started_q ? swp_q + {{(SWP_W-1){1'b0}}, 1'b1} : '0;
    else       cand_sweep = swp_q;
  end

  always_comb begin
    started_d = started_q;
    pow_d     = pow_q;
    max_d     = max_q;
    maxidx_d  = maxidx_q;
    pos_d     = pos_q;
    swp_d     = swp_q;
    if (clear) begin
      started_d = 1'b0;
      pow_d     = '0;
      max_d     = '0;
      maxidx_d  = '0;
      pos_d     = '0;
      swp_d     = '0;
    end else if (take) begin
      started_d = 1'b1;
      pow_d     = cand_pow;
      max_d     = cand_mag;
      maxidx_d  = cand_idx;
      pos_d     = samp_pos + {{(IDX_W-1){1'b0}}, 1'b1};
      swp_d     = cand_sweep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      pow_q     <= '0;
      max_q     <= '0;
      maxidx_q  <= '0;
      pos_q     <= '0;
      swp_q     <= '0;
    end else begin
      started_q <= started_d;
      pow_q     <= pow_d;
      max_q     <= max_d;
      maxidx_q  <= maxidx_d;
      pos_q     <= pos_d;
      swp_q     <= swp_d;
    end
  end

  // R7: within a sweep the running total never decreases (saturates)
  assert_pow_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !first && !clear) |=> (pow_q >= $past(pow_q)));

  // R5: position restarts at each sweep start
  assert_pos_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && first && !clear) |=> (pos_q == {{(IDX_W-1){1'b0}}, 1'b1}));

  // R8: nothing is taken before a sweep has begun
  assert_need_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !first) |-> started_q);

endmodule

// File: rtl/acq_peak_select.sv
module acq_peak_select
  import acq_pkg::*;
#(
  parameter int MAG_W = 32,
  parameter int IDX_W = 16,
  parameter int SWP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic [SWP_W-1:0] sweep_cfg,
  input  logic             take,
  input  logic             last,
  input  logic [MAG_W-1:0] cand_mag,
  input  logic [IDX_W-1:0] cand_idx,
  input  logic [MAG_W-1:0] cand_pow,
  input  logic [SWP_W-1:0] cand_sweep,
  output logic [MAG_W-1:0] peak_mag,
  output logic [IDX_W-1:0] peak_idx,
  output logic [SWP_W-1:0] peak_sweep,
  output logic [MAG_W-1:0] power_sum,
  output logic             busy,
  output logic             done
);

  localparam logic [SWP_W-1:0] ONE_SWP = {{(SWP_W-1){1'b0}}, 1'b1};

  run_state_e       state_q, state_d;
  logic [SWP_W-1:0] nsw_q, nsw_d;
  logic [MAG_W-1:0] pmag_q, pmag_d;
  logic [IDX_W-1:0] pidx_q, pidx_d;
  logic [SWP_W-1:0] pswp_q, pswp_d;
  logic [MAG_W-1:0] psum_q, psum_d;
  logic             fin_q, fin_d;
  logic             done_q, done_d;

  logic sweep_end, wins, final_end;

  always_comb begin
    sweep_end = take & last;
    wins      = sweep_end & (cand_mag > pmag_q);
    final_end = sweep_end & (cand_sweep == nsw_q - ONE_SWP);
  end

  always_comb begin
    state_d = state_q;
    nsw_d   = nsw_q;
    pmag_d  = pmag_q;
    pidx_d  = pidx_q;
    pswp_d  = pswp_q;
    psum_d  = psum_q;
    fin_d   = 1'b0;
    done_d  = 1'b0;
    if (run_start) begin
      state_d = RUN_ACTIVE;
      nsw_d   = (sweep_cfg == '0) ? ONE_SWP : sweep_cfg;
      pmag_d  = '0;
      pidx_d  = '0;
      pswp_d  = '0;
      psum_d  = '0;
    end else begin
      done_d = fin_q;
      if (wins) begin
        pmag_d = cand_mag;
        pidx_d = cand_idx;
        pswp_d = cand_sweep;
        psum_d = cand_pow;
      end
      if (final_end) begin
        state_d = RUN_IDLE;
        fin_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      nsw_q   <= ONE_SWP;
      pmag_q  <= '0;
      pidx_q  <= '0;
      pswp_q  <= '0;
      psum_q  <= '0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      nsw_q   <= nsw_d;
      pmag_q  <= pmag_d;
      pidx_q  <= pidx_d;
      pswp_q  <= pswp_d;
      psum_q  <= psum_d;
      fin_q   <= fin_d;
      done_q  <= done_d;
    end
  end

  assign peak_mag   = pmag_q;
  assign peak_idx   = pidx_q;
  assign peak_sweep = pswp_q;
  assign power_sum  = psum_q;
  assign busy       = (state_q == RUN_ACTIVE);
  assign done       = done_q;

  // R9: done lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: done only appears while the tracker is idle
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == RUN_IDLE));

  // R4: within a run the stored peak never decreases
  assert_peak_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_start |=> (pmag_q >= $past(pmag_q)));

  // R2: a run start empties the results
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (pmag_q == '0 && psum_q == '0 && pswp_q == '0 && !done_q));

  // R6: the recorded sweep is inside the configured run
  assert_sweep_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RUN_ACTIVE) |-> (pswp_q < nsw_q));

  // R8: results are frozen while idle
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RUN_IDLE && !run_start) |=> ($stable(pmag_q) && $stable(psum_q)));

endmodule

// File: rtl/acq_peak_tracker.sv
module acq_peak_tracker #(
  parameter int MAG_W = 32,
  parameter int IDX_W = 16,
  parameter int SWP_W = 8,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic [SWP_W-1:0] sweep_cfg,
  input  logic             sample_tick,
  input  logic             mag_valid,
  input  logic [MAG_W-1:0] mag_data,
  input  logic             sweep_first,
  input  logic             sweep_last,
  output logic [MAG_W-1:0] peak_mag,
  output logic [IDX_W-1:0] peak_idx,
  output logic [SWP_W-1:0] peak_sweep,
  output logic [MAG_W-1:0] power_sum,
  output logic [CNT_W/2-1:0] start_lo,
  output logic [CNT_W/2-1:0] start_hi,
  output logic             busy,
  output logic             done
);

  localparam int HALF_W = CNT_W / 2;

  logic             accum_en;
  logic             take;
  logic [MAG_W-1:0] cand_mag;
  logic [IDX_W-1:0] cand_idx;
  logic [MAG_W-1:0] cand_pow;
  logic [SWP_W-1:0] cand_sweep;

  assign accum_en = mag_valid & busy & ~run_start;

  acq_stamp #(
    .CNT_W (CNT_W),
    .HALF_W(HALF_W)
  ) u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sample_tick),
    .capture (run_start),
    .stamp_lo(start_lo),
    .stamp_hi(start_hi)
  );

  acq_sweep_accum #(
    .MAG_W(MAG_W),
    .IDX_W(IDX_W),
    .SWP_W(SWP_W)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (run_start),
    .en        (accum_en),
    .first     (sweep_first),
    .mag       (mag_data),
    .take      (take),
    .cand_mag  (cand_mag),
    .cand_idx  (cand_idx),
    .cand_pow  (cand_pow),
    .cand_sweep(cand_sweep)
  );

  acq_peak_select #(
    .MAG_W(MAG_W),
    .IDX_W(IDX_W),
    .SWP_W(SWP_W)
  ) u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_start (run_start),
    .sweep_cfg (sweep_cfg),
    .take      (take),
    .last      (sweep_last),
    .cand_mag  (cand_mag),
    .cand_idx  (cand_idx),
    .cand_pow  (cand_pow),
    .cand_sweep(cand_sweep),
    .peak_mag  (peak_mag),
    .peak_idx  (peak_idx),
    .peak_sweep(peak_sweep),
    .power_sum (power_sum),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: tb/sim_acq_peak_tracker.sv
module sim_acq_peak_tracker;

  logic        clk;
  logic        rst_n;
  logic        run_start;
  logic [7:0]  sweep_cfg;
  logic        sample_tick;
  logic        mag_valid;
  logic [31:0] mag_data;
  logic        sweep_first;
  logic        sweep_last;
  logic [31:0] peak_mag;
  logic [15:0] peak_idx;
  logic [7:0]  peak_sweep;
  logic [31:0] power_sum;
  logic [31:0] start_lo;
  logic [31:0] start_hi;
  logic        busy;
  logic        done;

  int checks;
  int errors;
  int cyc;
  longint unsigned tb_cnt;
  longint unsigned exp_stamp;
  logic [31:0] mags [0:63];

  acq_peak_tracker u0 (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .sweep_cfg(sweep_cfg),
    .sample_tick(sample_tick), .mag_valid(mag_valid), .mag_data(mag_data),
    .sweep_first(sweep_first), .sweep_last(sweep_last), .peak_mag(peak_mag),
    .peak_idx(peak_idx), .peak_sweep(peak_sweep), .power_sum(power_sum),
    .start_lo(start_lo), .start_hi(start_hi), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // independent count of sample ticks, captured at run start (R2)
  always @(posedge clk) begin
    if (rst_n) begin
      if (run_start) exp_stamp <= tb_cnt;
      if (sample_tick) tb_cnt <= tb_cnt + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    sample_tick <= (cyc % 3) != 0;
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    finish_sim();
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mag_valid   = 1'b0;
    mag_data    = 32'hFFFF_FFFF;
    sweep_first = 1'b1;
    sweep_last  = 1'b1;
  endtask

  task automatic send(input logic [31:0] m, input logic f, input logic l);
    mag_valid   = 1'b1;
    mag_data    = m;
    sweep_first = f;
    sweep_last  = l;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic start_run(input logic [7:0] cfg);
    sweep_cfg = cfg;
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    chk("R2 peak cleared", peak_mag, 0);
    chk("R2 power cleared", power_sum, 0);
    chk("R2 busy", busy, 1);
    chk("R3 stamp low word", start_lo, exp_stamp[31:0]);
    chk("R3 stamp high word", start_hi, exp_stamp[63:32]);
  endtask

  // stream nsw sweeps of len samples from mags[], then check against a model
  task automatic stream_and_check(input int nsw, input int len, input bit gaps,
                                  input bit junk, input string tag);
    logic [31:0] best;
    int bs, bi;
    logic [32:0] acc;
    logic [31:0] exp_pow;
    best = 0; bs = 0; bi = 0;
    if (junk) send(32'hFFFF_FFF0, 1'b0, 1'b0); // before any sweep start (R8)
    for (int s = 0; s < nsw; s++) begin
      for (int i = 0; i < len; i++) begin
        if (gaps && (s + i) > 0) @(negedge clk);
        send(mags[s*len+i], i == 0, i == len - 1);
        if (mags[s*len+i] > best) begin best = mags[s*len+i]; bs = s; bi = i; end
      end
    end
    acc = 0;
    for (int i = 0; i < len; i++) begin
      acc = acc + {1'b0, mags[bs*len+i]};
      if (acc[32]) acc = 33'h0_FFFF_FFFF;
    end
    exp_pow = acc[31:0];
    $display("scenario %s", tag);
    chk("R4 peak magnitude", peak_mag, best);
    chk("R5 peak index", peak_idx, bi);
    chk("R6 peak sweep", peak_sweep, bs);
    chk("R7 power sum", power_sum, exp_pow);
    chk("R9 busy low after final", busy, 0);
    chk("R9 done not yet", done, 0);
    @(negedge clk);
    chk("R9 done pulse", done, 1);
    @(negedge clk);
    chk("R9 done single", done, 0);
  endtask

  task automatic t_reset();
    chk("R1 peak", peak_mag, 0);
    chk("R1 index", peak_idx, 0);
    chk("R1 sweep", peak_sweep, 0);
    chk("R1 power", power_sum, 0);
    chk("R1 stamp", {start_hi, start_lo}, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_basic();
    for (int k = 0; k < 24; k++) mags[k] = 100 + 3 * (k % 8) + 7 * (k / 8);
    mags[13] = 5000;
    start_run(8'd3);
    stream_and_check(3, 8, 1'b0, 1'b0, "basic three sweeps R4 R5 R6");
  endtask

  task automatic t_ties();
    for (int k = 0; k < 24; k++) mags[k] = 10 + k;
    mags[2] = 900; mags[6] = 900; mags[17] = 900;
    start_run(8'd3);
    stream_and_check(3, 8, 1'b1, 1'b1, "ties with gaps and junk R4 R8");
    chk("R4 tie keeps earliest index", peak_idx, 2);
    chk("R4 tie keeps earliest sweep", peak_sweep, 0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 4; k++) mags[k] = 32'hC000_0000;
    start_run(8'd0);
    stream_and_check(1, 4, 1'b0, 1'b0, "saturation zero count R7 R9");
    chk("R7 saturated total", power_sum, 32'hFFFF_FFFF);
  endtask

  task automatic t_after_done();
    logic [31:0] held;
    held = peak_mag;
    send(32'hFFFF_FFFF, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 idle sample ignored", peak_mag, held);
    chk("R8 idle no done", done, 0);
  endtask

  task automatic t_restart();
    start_run(8'd4);
    for (int i = 0; i < 4; i++) send(32'd7000 + i, i == 0, i == 3);
    chk("R10 first sweep recorded", peak_mag, 7003);
    start_run(8'd2);
    chk("R10 restart cleared index", peak_idx, 0);
    for (int k = 0; k < 2; k++) mags[k] = 40 - k;
    stream_and_check(2, 1, 1'b0, 1'b0, "restart with one-sample sweeps R10");
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0; tb_cnt = 0; exp_stamp = 0;
    rst_n = 1'b0; run_start = 1'b0; sweep_cfg = 8'd1; sample_tick = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_basic();
    t_ties();
    t_saturate();
    t_after_done();
    t_restart();
    repeat (2) @(negedge clk);
    finish_sim();
  end

endmodule